// File: doc/BRIEF.md
# Wavefront Memory Wait-Count Tracker

This block sits beside the issue logic of a single wavefront. It counts the memory operations that the wavefront has in flight, split into three classes. The issue side pulses an increment strobe when it sends an operation, and the memory side pulses a decrement strobe when one completes. The block also holds the wavefront's issue status, a 3-bit code, and it drives a ready signal that allows the scheduler to issue from this wavefront.

A wait instruction loads one threshold per class and moves the wavefront into a waiting state. Issue stays blocked in that state. The block returns the wavefront to running once every class count has fallen to or below its threshold, and only while the oldest instruction in the wavefront is that wait instruction. A clear command drops every pending threshold. Each counter saturates instead of wrapping. A completion seen at a count of zero is discarded and raises a sticky error flag.

The three classes are:
- class 0: vector memory operations.
- class 1: vector stores together with export operations.
- class 2: a combined class. It covers local-share, global-share, scalar memory and message traffic, whichever of these the issue side signals.

Top module: `wf_waitcnt_tracker`

## Requirements
- R1: While `rst_ni` is low and after it is released, the block shows `status_o`=0 (stopped), all counts 0, `ready_o`=0 and `err_o`=0.
- R2: The status codes are stopped=0, returning=1, running=2, stalled=3 and waiting=4. A `stat_we_i` pulse with `stat_i` between 0 and 3 sets `status_o` to that value on the next edge. A `stat_we_i` pulse with `stat_i` of 4 or more is ignored. A `wait_load_i` in the same cycle overrides `stat_we_i`.
- R3: Each `inc_i[k]` pulse raises count k by one at the next edge. Count k sits in `cnt_o[6k+5:6k]`, and threshold k sits in `wait_thr_i[6k+5:6k]`. Class 0 is vector memory, class 1 is write/export and class 2 is the combined class.
- R4: A count of 63 stays at 63 when it is incremented.
- R5: A decrement of a count that is already 0, with no increment in the same cycle, leaves the count at 0. It also sets `err_o`, which stays high until reset.
- R6: An increment and a decrement of the same class in the same cycle leave that count unchanged.
- R7: `wait_load_i` captures all three thresholds. From the next cycle `status_o` reads 4, and `ready_o` is low while the status is waiting.
- R8: The block is waiting, `oldest_is_wait_i` is high, and every count is at or below its threshold in some cycle. Then `status_o` becomes 2 and `ready_o` rises in the following cycle. That cycle is the one after the count update that met the last condition.
- R9: While `oldest_is_wait_i` is low, a waiting block stays waiting even when all conditions are met.
- R10: A threshold of 63 never blocks its class. `clear_i` sets all three thresholds to 63 at the next edge, and it wins over a `wait_load_i` in the same cycle.
- R11: `ready_o` is high exactly when `status_o` is 2 (running).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | 3 | Per-class issue strobe |
| dec_i | input | 3 | Per-class completion strobe |
| wait_load_i | input | 1 | Wait instruction: load thresholds and enter waiting |
| wait_thr_i | input | 18 | Three packed 6-bit thresholds |
| clear_i | input | 1 | Reset all thresholds to 63 |
| oldest_is_wait_i | input | 1 | Oldest instruction of the wavefront is the wait |
| stat_we_i | input | 1 | Status write strobe |
| stat_i | input | 3 | Status value for a write |
| ready_o | output | 1 | Issue allowed |
| status_o | output | 3 | Status code |
| cnt_o | output | 18 | Three packed 6-bit outstanding counts |
| err_o | output | 1 | Sticky underflow flag |

## Verification
The assertions take two things for granted. First, the upstream logic has ended reset before it sends any strobe. Second, a status write that leaves the waiting state happens only through `stat_we_i` or the release path. They do not require that strobes be exclusive, so a simultaneous increment and decrement and a combined clear and load are legal. The stimulus drives every input just after a falling edge and returns the strobes to zero after one cycle. Underflow is provoked only once, at the end of the run, because the error flag is sticky.

// File: rtl/wf_wait_pkg.sv
package wf_wait_pkg;
  typedef enum logic [2:0] {
    ST_STOP  = 3'd0,
    ST_RET   = 3'd1,
    ST_RUN   = 3'd2,
    ST_STALL = 3'd3,
    ST_WAIT  = 3'd4
  } wf_stat_e;
endpackage

// File: rtl/wf_class_slot.sv
module wf_class_slot #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             thr_load_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             thr_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             met_o,
  output logic             uflow_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, thr_q;
  logic             uflow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      uflow_q <= 1'b0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10: if (cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
        2'b01: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else             uflow_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // clear beats load; all-ones means no wait
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         thr_q <= MAX;
    else if (thr_clr_i)  thr_q <= MAX;
    else if (thr_load_i) thr_q <= thr_i;
  end

  assign cnt_o   = cnt_q;
  assign met_o   = (cnt_q <= thr_q);
  assign uflow_o = uflow_q;
endmodule

// File: rtl/wf_status_fsm.sv
module wf_status_fsm
  import wf_wait_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wait_load_i,
  input  logic       stat_we_i,
  input  logic [2:0] stat_i,
  input  logic       all_met_i,
  input  logic       oldest_wait_i,
  output logic [2:0] stat_o,
  output logic       ready_o
);
  wf_stat_e st_q, st_d;
  logic     stat_ok;

  assign stat_ok = (stat_i <= 3'd3);

  always_comb begin
    st_d = st_q;
    if (wait_load_i)
      st_d = ST_WAIT;
    else if (stat_we_i && stat_ok)
      st_d = wf_stat_e'(stat_i);
    else if (st_q == ST_WAIT && all_met_i && oldest_wait_i)
      st_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_STOP;
    else         st_q <= st_d;
  end

  assign stat_o  = st_q;
  assign ready_o = (st_q == ST_RUN);
endmodule

// File: rtl/wf_waitcnt_tracker.sv
module wf_waitcnt_tracker #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned NCLS  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCLS-1:0]       inc_i,
  input  logic [NCLS-1:0]       dec_i,
  input  logic                  wait_load_i,
  input  logic [CNT_W*NCLS-1:0] wait_thr_i,
  input  logic                  clear_i,
  input  logic                  oldest_is_wait_i,
  input  logic                  stat_we_i,
  input  logic [2:0]            stat_i,
  output logic                  ready_o,
  output logic [2:0]            status_o,
  output logic [CNT_W*NCLS-1:0] cnt_o,
  output logic                  err_o
);
  logic [NCLS-1:0] met, uflow;

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    wf_class_slot #(.CNT_W(CNT_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (inc_i[k]),
      .dec_i      (dec_i[k]),
      .thr_load_i (wait_load_i),
      .thr_i      (wait_thr_i[k*CNT_W +: CNT_W]),
      .thr_clr_i  (clear_i),
      .cnt_o      (cnt_o[k*CNT_W +: CNT_W]),
      .met_o      (met[k]),
      .uflow_o    (uflow[k])
    );
  end

  wf_status_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wait_load_i   (wait_load_i),
    .stat_we_i     (stat_we_i),
    .stat_i        (stat_i),
    .all_met_i     (&met),
    .oldest_wait_i (oldest_is_wait_i),
    .stat_o        (status_o),
    .ready_o       (ready_o)
  );

  assign err_o = |uflow;
endmodule

// File: rtl/wf_waitcnt_tracker_chk.sv
module wf_waitcnt_tracker_chk #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned NCLS  = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NCLS-1:0]       inc_i,
  input logic [NCLS-1:0]       dec_i,
  input logic                  wait_load_i,
  input logic                  oldest_is_wait_i,
  input logic                  stat_we_i,
  input logic                  ready_o,
  input logic [2:0]            status_o,
  input logic [CNT_W*NCLS-1:0] cnt_o,
  input logic                  err_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  a_r2_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o <= 3'd4);

  a_r7_enter_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_load_i |=> (status_o == 3'd4 && !ready_o));

  a_r9_release_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 3'd2 && $past(status_o) == 3'd4) |->
      ($past(oldest_is_wait_i) || $past(stat_we_i)));

  a_r11_ready_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> status_o == 3'd2);

  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  for (genvar k = 0; k < NCLS; k++) begin : g_chk
    a_r3_inc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i[k] && !dec_i[k] && cnt_o[k*CNT_W +: CNT_W] != MAX) |=>
        cnt_o[k*CNT_W +: CNT_W] == $past(cnt_o[k*CNT_W +: CNT_W]) + 1'b1);

    a_r4_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i[k] && !dec_i[k] && cnt_o[k*CNT_W +: CNT_W] == MAX) |=>
        cnt_o[k*CNT_W +: CNT_W] == MAX);

    a_r5_underflow_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i[k] && !inc_i[k] && cnt_o[k*CNT_W +: CNT_W] == '0) |=>
        (err_o && cnt_o[k*CNT_W +: CNT_W] == '0));

    a_r6_both_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i[k] == dec_i[k]) |=> $stable(cnt_o[k*CNT_W +: CNT_W]));
  end
endmodule

bind wf_waitcnt_tracker wf_waitcnt_tracker_chk #(.CNT_W(CNT_W), .NCLS(NCLS)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .inc_i            (inc_i),
  .dec_i            (dec_i),
  .wait_load_i      (wait_load_i),
  .oldest_is_wait_i (oldest_is_wait_i),
  .stat_we_i        (stat_we_i),
  .ready_o          (ready_o),
  .status_o         (status_o),
  .cnt_o            (cnt_o),
  .err_o            (err_o)
);

// File: tb/wf_waitcnt_tracker_bench.sv
module wf_waitcnt_tracker_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  inc_i = '0, dec_i = '0;
  logic        wait_load_i = 1'b0, clear_i = 1'b0, oldest_is_wait_i = 1'b0;
  logic [17:0] wait_thr_i = '0;
  logic        stat_we_i = 1'b0;
  logic [2:0]  stat_i = '0;
  logic        ready_o, err_o;
  logic [2:0]  status_o;
  logic [17:0] cnt_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  wf_waitcnt_tracker u_wf_waitcnt_tracker (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc_i), .dec_i(dec_i),
    .wait_load_i(wait_load_i), .wait_thr_i(wait_thr_i), .clear_i(clear_i),
    .oldest_is_wait_i(oldest_is_wait_i), .stat_we_i(stat_we_i), .stat_i(stat_i),
    .ready_o(ready_o), .status_o(status_o), .cnt_o(cnt_o), .err_o(err_o)
  );

  function automatic int cnt(int k);
    return int'(cnt_o[k*6 +: 6]);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: inputs held since last negedge, strobes dropped afterwards
  task automatic step();
    @(negedge clk_i);
    inc_i = '0; dec_i = '0; wait_load_i = 0; clear_i = 0; stat_we_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 0);
    chk("R1 counts", cnt_o, 0);
    chk("R1 ready", ready_o, 0);
    chk("R1 err", err_o, 0);
    @(negedge clk_i); rst_ni = 1; step();
    chk("R1 status after release", status_o, 0);
  endtask

  task automatic t_status();
    stat_we_i = 1; stat_i = 3'd2; step();
    chk("R2 set running", status_o, 2); chk("R11 ready when running", ready_o, 1);
    stat_we_i = 1; stat_i = 3'd3; step();
    chk("R2 set stalled", status_o, 3); chk("R11 ready when stalled", ready_o, 0);
    stat_we_i = 1; stat_i = 3'd5; step();
    chk("R2 bad code ignored", status_o, 3);
    stat_we_i = 1; stat_i = 3'd1; step();
    chk("R2 set returning", status_o, 1);
    stat_we_i = 1; stat_i = 3'd2; step();
    chk("R2 back to running", status_o, 2);
  endtask

  task automatic t_count();
    for (int i = 0; i < 3; i++) begin inc_i = 3'b001; step(); end
    inc_i = 3'b110; step();
    inc_i = 3'b100; step();
    chk("R3 class0", cnt(0), 3); chk("R3 class1", cnt(1), 1); chk("R3 class2", cnt(2), 2);
    inc_i = 3'b001; dec_i = 3'b001; step();
    chk("R6 same-cycle inc/dec", cnt(0), 3);
  endtask

  task automatic t_wait();
    oldest_is_wait_i = 1;
    wait_load_i = 1; wait_thr_i = {6'd0, 6'd63, 6'd1};
    stat_we_i = 1; stat_i = 3'd3;   // load wins
    step();
    chk("R7 waiting", status_o, 4); chk("R7 ready low", ready_o, 0);
    chk("R2 load beats write", status_o, 4);
    dec_i = 3'b100; step(); dec_i = 3'b100; step();
    chk("R7 still waiting class0", status_o, 4);
    dec_i = 3'b001; step();
    chk("R8 not yet met", status_o, 4);
    dec_i = 3'b001; step();           // class0 now 1: last condition met
    chk("R8 met this cycle, status unchanged", status_o, 4);
    step();
    chk("R8 running next cycle", status_o, 2); chk("R8 ready", ready_o, 1);
    chk("R10 class1 threshold 63 no wait", cnt(1), 1);
  endtask

  task automatic t_oldest();
    oldest_is_wait_i = 0;
    wait_load_i = 1; wait_thr_i = '1; step();
    step(); step();
    chk("R9 held without wait at head", status_o, 4);
    chk("R11 ready low while held", ready_o, 0);
    oldest_is_wait_i = 1; step();
    chk("R9 released once wait at head", status_o, 2);
  endtask

  task automatic t_clear();
    wait_load_i = 1; wait_thr_i = '0; step();   // counts 1,1,0
    step();
    chk("R10 blocked by zero thresholds", status_o, 4);
    clear_i = 1; step();
    chk("R10 clear edge", status_o, 4);
    step();
    chk("R10 released after clear", status_o, 2);
    wait_load_i = 1; clear_i = 1; wait_thr_i = '0; step();
    chk("R10 load+clear enters wait", status_o, 4);
    step();
    chk("R10 clear wins over load", status_o, 2);
  endtask

  task automatic t_sat();
    for (int i = 0; i < 70; i++) begin inc_i = 3'b010; step(); end
    chk("R4 saturates", cnt(1), 63);
    chk("R4 no spill into class2", cnt(2), 0);
  endtask

  task automatic t_uflow();
    chk("R5 err clear before", err_o, 0);
    dec_i = 3'b100; step();
    chk("R5 count stays 0", cnt(2), 0); chk("R5 err raised", err_o, 1);
    inc_i = 3'b100; step(); step();
    chk("R5 err sticky", err_o, 1); chk("R5 counting resumes", cnt(2), 1);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #5;
    t_reset();
    t_status();
    t_count();
    t_wait();
    t_oldest();
    t_clear();
    t_sat();
    t_uflow();
    finish_run();
  end

  initial begin
    #(20 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule